// File: doc/BRIEF.md
# Single-to-Half-Width Brain-Float Narrowing Converter

This block narrows a 32-bit IEEE single-precision bit pattern to the 16-bit brain-float format, which keeps the sign and the full 8-bit exponent and shortens the mantissa to 7 bits. The conversion logic is combinational. One output register holds the result and a valid flag, so the block has a latency of one clock cycle.

An input whose exponent field is all ones (infinity or NaN) is narrowed by keeping its upper half unchanged, with no rounding. Every other input is rounded to nearest, ties to even, in one step: a bias is added to the whole input word and the upper half of the sum is kept. The bias is one less than half of the discarded range, plus the lowest kept bit. The block does not make NaNs quiet and does not protect NaN payloads. A NaN whose only set mantissa bits lie in the discarded half therefore comes out as infinity, and this is intended behaviour. No exception flags are raised and no other rounding mode is offered.

Top module: `f2b_convert`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `out_word` becomes 0x0000 and `out_valid` becomes 0.
- R2: When input bits [30:23] are all ones, the result is input bits [31:16] unchanged, with no rounding.
- R3: For all other inputs, the result is bits [31:16] of the 32-bit sum of the input, 0x7FFF and input bit 16. Any carry out of bit 31 is dropped.
- R4: When the lower half is exactly 0x8000 and input bit 16 is 0, the result is the truncated upper half.
- R5: When the lower half is exactly 0x8000 and input bit 16 is 1, the result is the upper half plus one.
- R6: A lower half below 0x8000 truncates. A lower half above 0x8000 rounds the upper half up by one.
- R7: A mantissa carry can propagate into the exponent. The largest finite values 0x7F7FFFFF and 0xFF7FFFFF become 0x7F80 and 0xFF80 (signed infinity).
- R8: The NaN input 0x7F800001 produces 0x7F80.
- R9: `out_valid` equals the value `in_valid` had one clock earlier. `out_word` loads only on a cycle with `in_valid` high and otherwise holds its value.
- R10: The sign bit of the result always equals input bit 31.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Marks `in_word` as a word to convert |
| in_word | input | 32 | Single-precision bit pattern |
| out_word | output | 16 | Registered brain-float result |
| out_valid | output | 1 | High one cycle after an accepted input |

## Verification
Two functions can land on the same output code in the same cycle: the special-value pass-through, and a rounding carry that ripples through the mantissa into an all-ones exponent. The first is provoked with true infinities and NaNs, including 0x7F800001. The second is provoked with the largest finite values of both signs and with a carry across a smaller exponent boundary. Each result is judged against a constant worked out by hand. The sign bit is checked to see that it never changes. The hold behaviour is judged by changing `in_word` while `in_valid` is low.

// File: rtl/f2b_pkg.sv
// Package: shared format widths for the narrowing converter.
// Assumes the source and destination formats share the sign and exponent
// layout and differ only in mantissa length.
package f2b_pkg;
    parameter int SRC_W = 32;   // source word width
    parameter int EXP_W = 8;    // exponent field width, common to both formats
    parameter int DST_W = 16;   // destination word width
endpackage

// File: rtl/f2b_special_detect.sv
// Module: flags a source word whose exponent field is all ones (Inf/NaN).
// Assumes the sign is the MSB and the exponent sits directly below it.
module f2b_special_detect #(
    parameter int SRC_W = 32,
    parameter int EXP_W = 8
) (
    input  logic [SRC_W-1:0] src,
    output logic             is_special
);
    localparam int EXP_TOP = SRC_W - 2;

    logic [EXP_W-1:0] exp_field;

    // Extract the exponent and compare it against all ones.
    always_comb begin
        exp_field  = src[EXP_TOP -: EXP_W];
        is_special = &exp_field;
    end
endmodule

// File: rtl/f2b_round_rne.sv
// Module: rounds the source word to nearest, ties to even, by adding a bias
// of (half of the dropped range - 1) plus the lowest kept bit, then keeping
// the upper DST_W bits. Assumes DST_W < SRC_W. The carry out of the MSB is dropped.
module f2b_round_rne #(
    parameter int SRC_W = 32,
    parameter int DST_W = 16
) (
    input  logic [SRC_W-1:0] src,
    output logic [DST_W-1:0] rounded
);
    localparam int DROP_W = SRC_W - DST_W;
    localparam logic [SRC_W-1:0] HALF_M1 = (SRC_W'(1) << (DROP_W - 1)) - SRC_W'(1);

    logic [SRC_W-1:0] bias;
    logic [SRC_W-1:0] sum;

    // Build the parity-dependent bias, add it, and keep the upper part.
    always_comb begin
        bias    = HALF_M1 + SRC_W'(src[DROP_W]);
        sum     = src + bias;
        rounded = sum[SRC_W-1 -: DST_W];
    end
endmodule

// File: rtl/f2b_out_reg.sv
// Module: output stage. It loads the result on a valid cycle and registers
// the valid flag on every cycle. Uses a synchronous, active-low reset.
module f2b_out_reg #(
    parameter int DST_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [DST_W-1:0] d,
    output logic [DST_W-1:0] q,
    output logic             q_valid
);
    // Capture data on load and follow the valid strobe with one cycle of delay.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q       <= '0;
            q_valid <= 1'b0;
        end else begin
            q_valid <= load;
            if (load) q <= d;
        end
    end
endmodule

// File: rtl/f2b_convert.sv
// Module: top of the single-to-brain-float converter. It chooses between the
// special-value pass-through and the rounded value, then registers the result.
// Assumes in_word is a raw single-precision bit pattern.
module f2b_convert #(
    parameter int SRC_W = f2b_pkg::SRC_W,
    parameter int EXP_W = f2b_pkg::EXP_W,
    parameter int DST_W = f2b_pkg::DST_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [SRC_W-1:0] in_word,
    output logic [DST_W-1:0] out_word,
    output logic             out_valid
);
    logic             special;
    logic [DST_W-1:0] rounded;
    logic [DST_W-1:0] next_word;

    f2b_special_detect #(.SRC_W(SRC_W), .EXP_W(EXP_W)) u_detect (
        .src        (in_word),
        .is_special (special)
    );

    f2b_round_rne #(.SRC_W(SRC_W), .DST_W(DST_W)) u_round (
        .src     (in_word),
        .rounded (rounded)
    );

    // Pick the truncated upper half for Inf/NaN and the rounded value otherwise.
    always_comb begin
        next_word = special ? in_word[SRC_W-1 -: DST_W] : rounded;
    end

    f2b_out_reg #(.DST_W(DST_W)) u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (in_valid),
        .d       (next_word),
        .q       (out_word),
        .q_valid (out_valid)
    );
endmodule

// File: rtl/f2b_convert_chk.sv
// Module: checker bound to f2b_convert. It relates the ports over time.
// The armed flop makes sure every $past value comes from a cycle after reset.
module f2b_convert_chk #(
    parameter int SRC_W = 32,
    parameter int EXP_W = 8,
    parameter int DST_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [SRC_W-1:0] in_word,
    input logic [DST_W-1:0] out_word,
    input logic             out_valid
);
    logic armed;

    // Arm one cycle after reset is released.
    always_ff @(posedge clk) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    AST_RESET_CLEAR: assert property (@(posedge clk)
        $past(!rst_n) |-> (out_word == '0 && !out_valid)); // R1

    AST_VALID_DELAY: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        out_valid == $past(in_valid)); // R9

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        !$past(in_valid) |-> $stable(out_word)); // R9

    AST_SPECIAL_PASS: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        ($past(in_valid) && $past(&in_word[SRC_W-2 -: EXP_W]))
        |-> out_word == $past(in_word[SRC_W-1 -: DST_W])); // R2

    AST_SIGN_KEPT: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        $past(in_valid) |-> out_word[DST_W-1] == $past(in_word[SRC_W-1])); // R10
endmodule

bind f2b_convert f2b_convert_chk #(.SRC_W(SRC_W), .EXP_W(EXP_W), .DST_W(DST_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_word   (in_word),
    .out_word  (out_word),
    .out_valid (out_valid)
);

// File: tb/tb_f2b_convert.sv
// Bench: directed tests for f2b_convert, one task per scenario.
module tb_f2b_convert;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_word = '0;
    logic [15:0] out_word;
    logic        out_valid;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    f2b_convert dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_word   (in_word),
        .out_word  (out_word),
        .out_valid (out_valid)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    // Present one word for one cycle, then compare the registered result.
    task automatic send(input string req, input logic [31:0] w, input logic [15:0] exp);
        @(negedge clk);
        in_word  = w;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check(req, {16'h0, out_word}, {16'h0, exp});
        check({req, " valid"}, {31'h0, out_valid}, 32'h1);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1 word", {16'h0, out_word}, 32'h0);
        check("R1 valid", {31'h0, out_valid}, 32'h0);
    endtask

    task automatic t_special();
        send("R2 neg NaN", 32'hFFC12345, 16'hFFC1);
        send("R2 pos inf", 32'h7F800000, 16'h7F80);
        send("R2 NaN no round", 32'h7FC1FFFF, 16'h7FC1);
        send("R8 NaN to inf", 32'h7F800001, 16'h7F80);
    endtask

    task automatic t_ties();
        send("R4 tie even", 32'h3F808000, 16'h3F80);
        send("R5 tie odd", 32'h3F818000, 16'h3F82);
        send("R4 neg tie even", 32'h80008000, 16'h8000);
        send("R5 neg tie odd", 32'h80018000, 16'h8002);
    endtask

    task automatic t_near();
        send("R6 below half", 32'h3F807FFF, 16'h3F80);
        send("R6 above half", 32'h3F808001, 16'h3F81);
        send("R3 pi", 32'h40490FDB, 16'h4049);
        send("R3 zero", 32'h00000000, 16'h0000);
        send("R10 negative", 32'hBFC00000, 16'hBFC0);
    endtask

    task automatic t_carry();
        send("R7 max pos", 32'h7F7FFFFF, 16'h7F80);
        send("R7 max neg", 32'hFF7FFFFF, 16'hFF80);
        send("R7 exp step", 32'h3F7FFFFF, 16'h3F80);
    endtask

    task automatic t_hold();
        send("R9 load", 32'h40400000, 16'h4040);
        @(negedge clk);
        in_word = 32'h12345678;
        @(negedge clk);
        check("R9 hold word", {16'h0, out_word}, 32'h4040);
        check("R9 idle valid", {31'h0, out_valid}, 32'h0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        t_special();
        t_ties();
        t_near();
        t_carry();
        t_hold();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 re-reset word", {16'h0, out_word}, 32'h0);
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule